// File: doc/BRIEF.md
# Register-Programmed SPI Flash Command Engine

This block is a small SPI master that runs exactly one serial-flash transaction from a bank of eight byte-wide registers. The host first loads the opcode, the low sixteen address bits and up to four write bytes. It then writes a command byte. The upper nibble of that byte selects one of eleven fixed frame shapes. The lower nibble supplies address bits 19:16. Writing the command byte launches the frame.

The engine asserts chip select and serialises the opcode, an optional three-byte address, optional write data and an optional dummy byte, MSB first, in SPI mode 0. It then clocks in zero to four reply bytes. Each reply byte lands back in the data registers. A busy flag covers the whole frame. While the flag is high the register bank is locked against host writes. After the flag drops, the host reads the reply through the same register port.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, busy is 0, the chip-select output (active low) is 1, SCK is 0 and all eight registers read 0.
- R2: The register map is: offset 0 opcode, offset 1 command, offset 2 address bits 15:8, offset 3 address bits 7:0, offsets 4 to 7 data. In the command register, bits 7:4 are the shape code and bits 3:0 are address bits 19:16. A host write to offset 1 with a code from 1 to 11 starts a frame. Busy is high from the next cycle until the cycle in which chip select returns high.
- R3: Codes 0 and 12 to 15 start nothing: busy stays 0 and chip select stays high. The written value is still stored and reads back.
- R4: The frame shapes, after the opcode byte, are:
  - code 1: nothing.
  - code 2: one write byte.
  - code 3: two read bytes.
  - code 4: address only.
  - code 5: address and one write byte.
  - code 6: address and four write bytes.
  - code 7: address, one dummy byte and four read bytes.
  - codes 8 to 11: address and then 1, 2, 3 or 4 read bytes respectively.

  MOSI is 0 during read bytes.
- R5: The address goes out as three bytes, most significant first. The first address byte is {4'b0000, command bits 3:0}. The next two are offset 2 and then offset 3.
- R6: Codes 2 and 5 send offset 4 as their write byte. Code 6 sends offsets 4, 5, 6 and 7 in that order.
- R7: Read byte i (counting from 0 in arrival order) is stored at offset 4+i. Data offsets beyond the read count keep their previous contents.
- R8: For code 7, the dummy byte is sent as 0x00. The MISO data received during the dummy byte is discarded, so offset 4 holds the first byte that arrives after the dummy.
- R9: The SPI lines use mode 0. SCK idles low. MOSI changes only while SCK is low. Bits go out MSB first. The SCK period is CLK_DIV system clocks with a 50 % duty cycle.
- R10: The first SCK rising edge comes CLK_DIV + CLK_DIV/2 system clocks after chip select falls. Chip select rises CLK_DIV system clocks after the last SCK falling edge.
- R11: Host writes to any offset while busy is high are ignored. This includes a second command write, which does not restart or extend the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWr | input | 1 | Register write strobe |
| hostAddr | input | 3 | Register offset for reads and writes |
| hostWrData | input | 8 | Register write data |
| hostRdData | output | 8 | Register contents at hostAddr (combinational) |
| busy | output | 1 | Frame in progress |
| spiCsN | output | 1 | Flash chip select, active low |
| spiSck | output | 1 | SPI serial clock |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A behavioural flash responder logs every MOSI bit and answers with a position-dependent byte pattern. The bench can therefore detect the following faults:
- An address nibble taken from the wrong half of the command byte, which garbles the first address byte.
- A write or read count that is off by one, which changes the logged bit count and shifts the stored reply.
- A dummy byte that is not discarded, which leaves a reply shifted by one byte in offsets 4 to 7.
- A read that runs over and clobbers data offsets it does not own.

The bench also writes the invalid codes 0 and 12 to 15, which must not produce a chip-select edge. It measures the chip-select lead and trail gaps and the frame duration against the clock divider. Finally, it writes to the opcode, address and command registers during a frame. A design that lets those writes through would send a changed opcode later or restart the frame with a different bit count.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 8;
  localparam int OFS_W    = $clog2(NUM_REGS);
  localparam logic [OFS_W-1:0] CMD_OFS = OFS_W'(1);

  typedef enum logic [2:0] {BK_OP, BK_ADDR, BK_WR, BK_DUMMY, BK_RD} byteKind_t;

  typedef struct packed {
    logic       valid;
    logic       hasAddr;
    logic [2:0] nWr;
    logic       hasDummy;
    logic [2:0] nRd;
  } frameShape_t;

  typedef struct packed {
    byteKind_t  kind;
    logic [1:0] sub;
  } byteSel_t;

  // control -> datapath strobes
  typedef struct packed {
    logic       load;    // load txShift with the byte named by kind/sub
    logic       shift;   // advance MOSI by one bit
    logic       sample;  // capture MISO into rxShift
    logic       store;   // write rxShift into data register rdIdx
    byteKind_t  kind;
    logic [1:0] sub;
    logic [1:0] rdIdx;
  } dpStrobe_t;

  function automatic frameShape_t decodeMode(input logic [3:0] code);
    frameShape_t s;
    s = '0;
    s.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.nWr = 3'd1;
      4'h3: s.nRd = 3'd2;
      4'h4: s.hasAddr = 1'b1;
      4'h5: begin s.hasAddr = 1'b1; s.nWr = 3'd1; end
      4'h6: begin s.hasAddr = 1'b1; s.nWr = 3'd4; end
      4'h7: begin s.hasAddr = 1'b1; s.hasDummy = 1'b1; s.nRd = 3'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.hasAddr = 1'b1;
        s.nRd     = 3'(code - 4'h7);
      end
      default: s.valid = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic [3:0] frameLen(input frameShape_t s);
    return 4'(1 + (s.hasAddr ? 3 : 0) + int'(s.nWr) + int'(s.hasDummy) + int'(s.nRd));
  endfunction

  function automatic byteSel_t byteInfo(input frameShape_t s, input logic [3:0] idx);
    byteSel_t r;
    int p;
    r.kind = BK_RD;
    r.sub  = '0;
    p = int'(idx);
    if (p == 0) begin
      r.kind = BK_OP;
    end else begin
      p = p - 1;
      if (s.hasAddr && p < 3) begin
        r.kind = BK_ADDR;
        r.sub  = 2'(p);
      end else begin
        if (s.hasAddr) p = p - 3;
        if (p < int'(s.nWr)) begin
          r.kind = BK_WR;
          r.sub  = 2'(p);
        end else begin
          p = p - int'(s.nWr);
          if (s.hasDummy && p == 0) begin
            r.kind = BK_DUMMY;
          end else begin
            if (s.hasDummy) p = p - 1;
            r.kind = BK_RD;
            r.sub  = 2'(p);
          end
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic [OFS_W-1:0]     hostAddr,
  input  logic [3:0]           modeCode,
  output logic                 busy,
  output logic                 spiCsN,
  output logic                 spiSck,
  output dpStrobe_t            strobe
);

  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] CNT_LAST = DW'(CLK_DIV - 1);
  localparam logic [DW-1:0] CNT_MID  = DW'(HALF - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TRAIL} state_t;

  state_t      state;
  logic [DW-1:0] divCnt;
  logic [2:0]  bitCnt;
  logic [3:0]  byteIdx;
  logic [3:0]  lastIdx;
  frameShape_t shape;
  frameShape_t launchShape;
  byteSel_t    curSel;
  byteSel_t    nextSel;
  logic        cmdWr;
  logic        launch;
  logic        sckRise;
  logic        sckFall;
  logic        byteEnd;

  assign launchShape = decodeMode(modeCode);
  assign cmdWr   = hostWr && (hostAddr == CMD_OFS) && (state == ST_IDLE);
  assign launch  = cmdWr && launchShape.valid;
  assign sckRise = (state == ST_XFER) && (divCnt == CNT_MID);
  assign sckFall = (state == ST_XFER) && (divCnt == CNT_LAST);
  assign byteEnd = sckFall && (bitCnt == 3'd7);
  assign curSel  = byteInfo(shape, byteIdx);
  assign nextSel = byteInfo(shape, byteIdx + 4'd1);

  always_comb begin
    strobe        = '0;
    strobe.load   = launch || (byteEnd && (byteIdx != lastIdx));
    strobe.kind   = launch ? BK_OP : nextSel.kind;
    strobe.sub    = launch ? 2'd0 : nextSel.sub;
    strobe.sample = sckRise;
    strobe.shift  = sckFall && (bitCnt != 3'd7);
    strobe.store  = byteEnd && (curSel.kind == BK_RD);
    strobe.rdIdx  = curSel.sub;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      divCnt  <= '0;
      bitCnt  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      shape   <= '0;
      spiCsN  <= 1'b1;
      spiSck  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (launch) begin
            state   <= ST_LEAD;
            shape   <= launchShape;
            lastIdx <= frameLen(launchShape) - 4'd1;
            byteIdx <= '0;
            bitCnt  <= '0;
            divCnt  <= '0;
            spiCsN  <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (divCnt == CNT_LAST) begin
            divCnt <= '0;
            state  <= ST_XFER;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_XFER: begin
          divCnt <= (divCnt == CNT_LAST) ? '0 : divCnt + 1'b1;
          if (sckRise) spiSck <= 1'b1;
          if (sckFall) begin
            spiSck <= 1'b0;
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (byteIdx == lastIdx) state <= ST_TRAIL;
              else                    byteIdx <= byteIdx + 4'd1;
            end
          end
        end
        default: begin
          if (divCnt == CNT_LAST) begin
            divCnt <= '0;
            state  <= ST_IDLE;
            spiCsN <= 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |=> (busy && !spiCsN)); // R2
  AST_BUSY_ENDS_WITH_CS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> $fell(busy)); // R2
  AST_NO_LAUNCH_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !launchShape.valid) |=> (!busy && spiCsN)); // R3
  AST_SCK_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    spiSck |-> !spiCsN); // R9
  AST_IDLE_LINES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (spiCsN && !spiSck)); // R10

endmodule

// File: rtl/flash_cmd_dp.sv
`timescale 1ns/1ps
module flash_cmd_dp
  import flash_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWr,
  input  logic [OFS_W-1:0]     hostAddr,
  input  logic [BYTE_W-1:0]    hostWrData,
  output logic [BYTE_W-1:0]    hostRdData,
  input  logic                 busy,
  input  dpStrobe_t            strobe,
  input  logic                 spiMiso,
  output logic                 spiMosi
);

  logic [BYTE_W-1:0] regFile [NUM_REGS];
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txByte;

  always_comb begin
    case (strobe.kind)
      BK_OP:   txByte = regFile[0];
      BK_ADDR: begin
        case (strobe.sub)
          2'd0:    txByte = {4'h0, regFile[1][3:0]};
          2'd1:    txByte = regFile[2];
          default: txByte = regFile[3];
        endcase
      end
      BK_WR:   txByte = regFile[{1'b1, strobe.sub}];
      default: txByte = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else begin
      if (hostWr && !busy) regFile[hostAddr] <= hostWrData;
      if (strobe.store)    regFile[{1'b1, strobe.rdIdx}] <= rxShift;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load)       txShift <= txByte;
      else if (strobe.shift) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strobe.sample)     rxShift <= {rxShift[BYTE_W-2:0], spiMiso};
    end
  end

  assign spiMosi    = txShift[BYTE_W-1];
  assign hostRdData = regFile[hostAddr];

  AST_OPCODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWr) |=> $stable(regFile[0])); // R11
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWr) |=> $stable(regFile[1])); // R11
  AST_DUMMY_SENDS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.kind == BK_DUMMY && busy) |=> (spiMosi == 1'b0)); // R8

endmodule

// File: rtl/flash_cmd_engine.sv
`timescale 1ns/1ps
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic [2:0] hostAddr,
  input  logic [7:0] hostWrData,
  output logic [7:0] hostRdData,
  output logic       busy,
  output logic       spiCsN,
  output logic       spiSck,
  output logic       spiMosi,
  input  logic       spiMiso
);

  dpStrobe_t strobe;

  flash_cmd_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWr   (hostWr),
    .hostAddr (hostAddr),
    .modeCode (hostWrData[7:4]),
    .busy     (busy),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck),
    .strobe   (strobe)
  );

  flash_cmd_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWr     (hostWr),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .busy       (busy),
    .strobe     (strobe),
    .spiMiso    (spiMiso),
    .spiMosi    (spiMosi)
  );

  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (spiSck && $past(spiSck)) |-> $stable(spiMosi)); // R9

endmodule

// File: tb/sim_flash_cmd_engine.sv
`timescale 1ns/1ps
module sim_flash_cmd_engine;

  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int TCLK = 4;

  // [63:56] command byte, [55:48] opcode, [47:32] address 15:0, [31:0] data (31:24 = offset 4)
  localparam logic [63:0] VECS [12] = '{
    64'h10_06_0000_00000000,
    64'h20_01_0000_9C112233,
    64'h30_9F_0000_44556677,
    64'h4A_20_1234_00000000,
    64'h5F_02_ABCD_5A000000,
    64'h63_02_0F00_DEADBEEF,
    64'h71_0B_2000_11223344,
    64'h85_03_0101_CAFEF00D,
    64'h92_03_7777_01020304,
    64'hAE_03_8421_F0E0D0C0,
    64'hBF_03_FFFF_0BADCAFE,
    64'h80_03_0000_A5A5A5A5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0;
  logic [2:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic busy, spiCsN, spiSck, spiMosi, spiMiso;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #(TCLK/2) clk = ~clk;

  flash_cmd_engine #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busy(busy),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // ---------------- behavioural flash responder ----------------
  int seed = 0;
  int bitCount = 0;
  int frameCount = 0;
  logic [7:0] mosiLog [16];
  logic misoReg = 1'b0;
  longint csFallT = 0, firstRiseT = 0, lastFallT = 0, csRiseT = 0;

  function automatic logic [7:0] replyByte(input int idx, input int sd);
    return 8'((idx * 29 + 60) ^ sd);
  endfunction

  assign spiMiso = misoReg;

  always @(negedge spiCsN) begin
    logic [7:0] rb;
    bitCount = 0;
    frameCount++;
    csFallT = $time;
    for (int i = 0; i < 16; i++) mosiLog[i] = '0;
    rb = replyByte(0, seed);
    misoReg = rb[7];
  end

  always @(posedge spiCsN) csRiseT = $time;

  always @(posedge spiSck) begin
    if (bitCount == 0) firstRiseT = $time;
    if (bitCount < 128) mosiLog[bitCount/8] = {mosiLog[bitCount/8][6:0], spiMosi};
    bitCount++;
  end

  always @(negedge spiSck) begin
    logic [7:0] rb;
    lastFallT = $time;
    rb = replyByte(bitCount / 8, seed);
    misoReg = rb[7 - (bitCount % 8)];
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    hostAddr = a;
    #1;
    d = hostRdData;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic tbShape(input logic [3:0] c, output int na, output int nw,
                         output int nd, output int nr);
    na = 0; nw = 0; nd = 0; nr = 0;
    case (c)
      4'h2: nw = 1;
      4'h3: nr = 2;
      4'h4: na = 3;
      4'h5: begin na = 3; nw = 1; end
      4'h6: begin na = 3; nw = 4; end
      4'h7: begin na = 3; nd = 1; nr = 4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin na = 3; nr = int'(c) - 7; end
      default: ;
    endcase
  endtask

  task automatic runVec(input logic [63:0] v, input int sd);
    logic [7:0] mode, op, rd;
    logic [15:0] addr;
    logic [31:0] wd;
    logic [7:0] expB [12];
    string tagB [12];
    int na, nw, nd, nr, len, p, f0, rdPos;
    string rq;
    mode = v[63:56]; op = v[55:48]; addr = v[47:32]; wd = v[31:0];
    tbShape(mode[7:4], na, nw, nd, nr);
    len = 0;
    expB[len] = op; tagB[len] = "R4"; len++;
    if (na == 3) begin
      expB[len] = {4'h0, mode[3:0]}; tagB[len] = "R5"; len++;
      expB[len] = addr[15:8];        tagB[len] = "R5"; len++;
      expB[len] = addr[7:0];         tagB[len] = "R5"; len++;
    end
    for (int i = 0; i < nw; i++) begin
      expB[len] = wd[31 - 8*i -: 8]; tagB[len] = "R6"; len++;
    end
    if (nd == 1) begin expB[len] = 8'h00; tagB[len] = "R8"; len++; end
    rdPos = len;
    for (int i = 0; i < nr; i++) begin expB[len] = 8'h00; tagB[len] = "R4"; len++; end

    seed = sd;
    f0 = frameCount;
    regWrite(3'd0, op);
    regWrite(3'd2, addr[15:8]);
    regWrite(3'd3, addr[7:0]);
    for (int i = 0; i < 4; i++) regWrite(3'(4 + i), wd[31 - 8*i -: 8]);
    regWrite(3'd1, mode);
    check(busy == 1'b1, "R2", "busy after command write", longint'(busy), 1);
    waitIdle();
    @(negedge clk);
    check(frameCount == f0 + 1, "R2", "one frame per command", frameCount - f0, 1);
    check(bitCount == 8 * len, "R4", $sformatf("bit count mode %02h", mode), bitCount, 8 * len);
    for (int i = 0; i < len; i++)
      check(mosiLog[i] == expB[i], tagB[i], $sformatf("MOSI byte %0d mode %02h", i, mode),
            mosiLog[i], expB[i]);
    check((firstRiseT - csFallT) == longint'((DIV + HALF) * TCLK), "R10", "lead gap ns",
          firstRiseT - csFallT, (DIV + HALF) * TCLK);
    check((csRiseT - lastFallT) == longint'(DIV * TCLK), "R10", "trail gap ns",
          csRiseT - lastFallT, DIV * TCLK);
    p = DIV * 8 * len - HALF;
    check((lastFallT - firstRiseT) == longint'(p * TCLK), "R9", "frame SCK span ns",
          lastFallT - firstRiseT, p * TCLK);
    rq = (nd == 1) ? "R8" : "R7";
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      regRead(3'(4 + i), rd);
      e = (i < nr) ? replyByte(rdPos + i, sd) : wd[31 - 8*i -: 8];
      check(rd == e, rq, $sformatf("data reg %0d mode %02h", 4 + i, mode), rd, e);
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] rd;
    int f0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(spiCsN == 1'b1, "R1", "chip select after reset", spiCsN, 1);
    check(spiSck == 1'b0, "R1", "SCK after reset", spiSck, 0);
    for (int i = 0; i < 8; i++) begin
      regRead(3'(i), rd);
      check(rd == 8'h00, "R1", $sformatf("reg %0d after reset", i), rd, 0);
    end

    // table of all valid shapes
    for (int k = 0; k < 12; k++) runVec(VECS[k], k * 37 + 5);

    // R3 invalid codes
    for (int c = 0; c < 16; c++) begin
      if (c == 0 || c >= 12) begin
        f0 = frameCount;
        regWrite(3'd1, {4'(c), 4'h5});
        repeat (3 * DIV) @(negedge clk);
        check(busy == 1'b0, "R3", $sformatf("busy after code %0d", c), busy, 0);
        check(frameCount == f0, "R3", $sformatf("frames after code %0d", c), frameCount - f0, 0);
        regRead(3'd1, rd);
        check(rd == {4'(c), 4'h5}, "R3", "invalid command stored", rd, {4'(c), 4'h5});
      end
    end

    // R11 writes while busy are ignored
    seed = 3;
    f0 = frameCount;
    regWrite(3'd0, 8'h05);
    regWrite(3'd2, 8'h12);
    regWrite(3'd1, 8'h30);
    regWrite(3'd0, 8'hFF);
    regWrite(3'd2, 8'hEE);
    regWrite(3'd1, 8'h10);
    waitIdle();
    @(negedge clk);
    check(frameCount == f0 + 1, "R11", "frames with busy command write", frameCount - f0, 1);
    check(bitCount == 24, "R11", "bit count not restarted", bitCount, 24);
    check(mosiLog[0] == 8'h05, "R11", "opcode sent", mosiLog[0], 8'h05);
    regRead(3'd0, rd);
    check(rd == 8'h05, "R11", "opcode reg after busy write", rd, 8'h05);
    regRead(3'd2, rd);
    check(rd == 8'h12, "R11", "addr reg after busy write", rd, 8'h12);
    regRead(3'd1, rd);
    check(rd == 8'h30, "R11", "command reg after busy write", rd, 8'h30);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule